// File: doc/BRIEF.md
# Reset and Programming Mode Entry Detector

This block sits behind the reset and program-strobe pins of a small microcontroller and runs from the oscillator clock. It measures how long the reset pin stays high in machine cycles. Once the pin has been high for long enough it drives the internal device reset. When the pin is released, it chooses how the device starts. A machine cycle is 12 oscillator clocks in the standard clock mode and 6 in the double-speed mode.

If the program-strobe pin shows a high-to-low transition while reset is held, and the pin has already been high for more than ten machine cycles at that point, the device starts in external host programming mode when reset is released. In every other case it starts in normal operation mode. Both pins pass through two-flop synchronisers before any counting or edge detection. The mode chosen at release is held until the next recognised reset. A separate asynchronous power-on input, which comes from the analog supervisor, initialises the block.

Top module: `rstmode_detect`

## Requirements
- R1: Both pins pass through a two-stage synchroniser. For a reset pin that rises and stays high, `core_rst` is first seen high 2·L+2 clock edges after the first rising edge that samples the pin high. L is the machine-cycle length in clocks.
- R2: `core_rst` asserts when the reset pin has been sampled high on at least 2·L consecutive edges.
- R3: If the reset pin is high for fewer than 2·L consecutive samples, `core_rst` does not assert. The cycle count clears, so a second short pulse also fails to assert reset.
- R4: L is 12 when `half_cycle` is 0 and 6 when `half_cycle` is 1. The value applies to both the reset threshold and the host-mode threshold.
- R5: A falling edge on the synchronised strobe pin, seen while reset is held and after at least 11 full machine cycles of high reset, makes `host_mode`=1 and `run_normal`=0 when reset is released.
- R6: A strobe falling edge seen before 11 full machine cycles have elapsed is ignored, and the device starts normally.
- R7: If no qualifying strobe edge occurs, release gives `run_normal`=1 and `host_mode`=0.
- R8: While reset is recognised and the pin is still high, both flags are 0. At release, exactly one flag is set.
- R9: Outside a recognised reset, the flags do not change. Strobe activity and short reset pulses leave the mode as it is.
- R10: After power-on (`por_n` low), `core_rst`=0, `run_normal`=1 and `host_mode`=0.
- R11: `core_rst` negates one clock after the synchronised reset pin goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| rst_pin | input | 1 | Reset pin level, asynchronous |
| psen_pin | input | 1 | Program-strobe pin level, asynchronous |
| half_cycle | input | 1 | 1 selects 6 clocks per machine cycle, 0 selects 12 |
| core_rst | output | 1 | Internal device reset, active high |
| host_mode | output | 1 | Device starts in external host programming mode |
| run_normal | output | 1 | Device starts in normal operation mode |

## Verification
The in-line assertions check these properties on every cycle:
- the two flags are never both set;
- the flags are cleared during a recognised reset and are stable outside one;
- the cycle count clears once the pin drops;
- the internal reset never rises without the pin held.

Only the bench scenarios can show that the thresholds fall at the exact cycle counts. These include the 2·L versus 2·L−1 boundary in both clock modes, the qualified and early strobe edges, and the release latency. A behavioural reference model is compared against the design on every clock for these cases.

// File: rtl/rstmode_pkg.sv
package rstmode_pkg;
  localparam int unsigned STD_MC_CLKS  = 12;
  localparam int unsigned FAST_MC_CLKS = 6;
  localparam int unsigned RESET_MCS    = 2;
  localparam int unsigned HOST_MCS     = 11;

  // machine-cycle length in oscillator clocks for the selected clock mode
  function automatic int unsigned mc_len(input logic fast,
                                         input int unsigned std_len,
                                         input int unsigned fast_len);
    return fast ? fast_len : std_len;
  endfunction
endpackage

// File: rtl/rmd_sync2.sv
module rmd_sync2 #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rmd_mcycle_timer.sv
module rmd_mcycle_timer
  import rstmode_pkg::*;
#(
  parameter int unsigned STD_CLKS  = STD_MC_CLKS,
  parameter int unsigned FAST_CLKS = FAST_MC_CLKS,
  parameter int unsigned RESET_MC  = RESET_MCS,
  parameter int unsigned HOST_MC   = HOST_MCS
) (
  input  logic clk,
  input  logic por_n,
  input  logic hold,
  input  logic fast,
  output logic core_rst,
  output logic host_qual
);
  localparam int unsigned PH_W = $clog2(STD_CLKS);
  localparam int unsigned MC_W = $clog2(HOST_MC + 1);

  logic [PH_W-1:0] ph;
  logic [MC_W-1:0] mc;
  logic [PH_W-1:0] ph_last;
  logic            mc_tick;
  logic            mc_full;

  assign ph_last = PH_W'(mc_len(fast, STD_CLKS, FAST_CLKS) - 1);
  assign mc_tick = hold && (ph >= ph_last);
  assign mc_full = (mc == MC_W'(HOST_MC));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ph <= '0;
      mc <= '0;
    end else if (!hold) begin
      ph <= '0;
      mc <= '0;
    end else if (mc_tick) begin
      ph <= '0;
      if (!mc_full) mc <= mc + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign core_rst  = (mc >= MC_W'(RESET_MC));
  assign host_qual = (mc >= MC_W'(HOST_MC));

  AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    !hold |=> (mc == '0)) else $error("count kept after pin drop"); // R3
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!por_n)
    (mc_tick && !mc_full) |=> (mc == $past(mc) + 1'b1)) else $error("machine cycle lost"); // R2
  AST_RST_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst) |-> $past(hold)) else $error("reset without pin"); // R2
endmodule

// File: rtl/rmd_mode_latch.sv
module rmd_mode_latch (
  input  logic clk,
  input  logic por_n,
  input  logic hold,
  input  logic core_rst,
  input  logic host_qual,
  input  logic strobe_fall,
  output logic host_mode,
  output logic run_normal
);
  logic pend;
  logic arm_host;
  logic release_evt;
  logic enter_rst;

  assign arm_host    = hold && host_qual && strobe_fall;
  assign release_evt = !hold && core_rst;
  assign enter_rst   = hold && core_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend       <= 1'b0;
      host_mode  <= 1'b0;
      run_normal <= 1'b1;
    end else begin
      if (!hold)         pend <= 1'b0;
      else if (arm_host) pend <= 1'b1;
      if (release_evt) begin
        host_mode  <= pend;
        run_normal <= !pend;
      end else if (enter_rst) begin
        host_mode  <= 1'b0;
        run_normal <= 1'b0;
      end
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
    !(host_mode && run_normal)) else $error("both modes set"); // R8
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    enter_rst |=> (!host_mode && !run_normal)) else $error("flag set in reset"); // R8
  AST_ONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    release_evt |=> (host_mode != run_normal)) else $error("no mode at release"); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!por_n)
    !core_rst |=> ($stable(host_mode) && $stable(run_normal))) else $error("mode moved"); // R9
  AST_HOST_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(host_mode) |-> $past(!hold)) else $error("host mode early"); // R5
endmodule

// File: rtl/rstmode_detect.sv
module rstmode_detect
  import rstmode_pkg::*;
#(
  parameter int unsigned STD_CLKS  = STD_MC_CLKS,
  parameter int unsigned FAST_CLKS = FAST_MC_CLKS,
  parameter int unsigned RESET_MC  = RESET_MCS,
  parameter int unsigned HOST_MC   = HOST_MCS
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic psen_pin,
  input  logic half_cycle,
  output logic core_rst,
  output logic host_mode,
  output logic run_normal
);
  logic [1:0] sync_q;
  logic       rst_s;
  logic       psen_s;
  logic       psen_q;
  logic       psen_fall;
  logic       host_qual;

  rmd_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .por_n(por_n), .d({psen_pin, rst_pin}), .q(sync_q)
  );
  assign rst_s  = sync_q[0];
  assign psen_s = sync_q[1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) psen_q <= 1'b1;
    else        psen_q <= psen_s;
  end
  assign psen_fall = psen_q && !psen_s;

  rmd_mcycle_timer #(
    .STD_CLKS(STD_CLKS), .FAST_CLKS(FAST_CLKS),
    .RESET_MC(RESET_MC), .HOST_MC(HOST_MC)
  ) u_timer (
    .clk(clk), .por_n(por_n), .hold(rst_s), .fast(half_cycle),
    .core_rst(core_rst), .host_qual(host_qual)
  );

  rmd_mode_latch u_latch (
    .clk(clk), .por_n(por_n), .hold(rst_s), .core_rst(core_rst),
    .host_qual(host_qual), .strobe_fall(psen_fall),
    .host_mode(host_mode), .run_normal(run_normal)
  );

  AST_RESET_DROPS: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_s && core_rst) |=> !core_rst) else $error("reset stuck"); // R11
endmodule

// File: tb/rstmode_detect_bench.sv
module rstmode_detect_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n, rst_pin, psen_pin, half_cycle;
  logic core_rst, host_mode, run_normal;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int first_seen = -1;
  int t0 = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstmode_detect u_rstmode_detect (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .psen_pin(psen_pin),
    .half_cycle(half_cycle), .core_rst(core_rst), .host_mode(host_mode),
    .run_normal(run_normal)
  );

  // inputs as seen by the design at each rising edge
  logic cap_r, cap_p, cap_f, cap_por;
  always @(posedge clk) begin
    cap_r   <= rst_pin;
    cap_p   <= psen_pin;
    cap_f   <= half_cycle;
    cap_por <= por_n;
  end

  // behavioural reference: pin history, count of high samples, mode state
  int  hi;
  bit  r1, r2, p1, p2, p3, m_pend, m_host, m_run;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int  len;
    bit  rs, fall, in_rst;
    cyc++;
    if (!cap_por) begin
      r1 = 0; r2 = 0; p1 = 1; p2 = 1; p3 = 1;
      hi = 0; m_pend = 0; m_host = 0; m_run = 1;
    end else begin
      len    = cap_f ? 6 : 12;
      rs     = r2;
      fall   = p3 && !p2;
      in_rst = (hi >= 2 * len);
      if (!rs) begin
        if (in_rst) begin m_host = m_pend; m_run = !m_pend; end
        m_pend = 0;
      end else begin
        if (in_rst) begin m_host = 0; m_run = 0; end
        if (fall && hi >= 11 * len) m_pend = 1;
      end
      hi = rs ? hi + 1 : 0;
      p3 = p2; p2 = p1; p1 = cap_p;
      r2 = r1; r1 = cap_r;
      check(core_rst == (hi >= 2 * len), "R2", "core_rst per cycle", core_rst, hi >= 2 * len);
      check(host_mode == m_host, "R5/R8", "host_mode per cycle", host_mode, m_host);
      check(run_normal == m_run, "R7/R8", "run_normal per cycle", run_normal, m_run);
    end
    if (core_rst && first_seen < 0) first_seen = cyc;
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hold_rst(input int n, input int fall_at);
    @(negedge clk); #1;
    t0 = cyc;
    first_seen = -1;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin @(negedge clk); #1; end
      rst_pin = 1'b1;
      if (i == fall_at)     psen_pin = 1'b0;
      if (i == fall_at + 3) psen_pin = 1'b1;
    end
    @(negedge clk); #1;
    rst_pin  = 1'b0;
    psen_pin = 1'b1;
    repeat (6) @(negedge clk);
    #1;
  endtask

  initial begin
    por_n = 1'b0; rst_pin = 1'b0; psen_pin = 1'b1; half_cycle = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(core_rst == 1'b0, "R10", "core_rst after power-on", core_rst, 0);
    check(run_normal == 1'b1, "R10", "run_normal after power-on", run_normal, 1);
    check(host_mode == 1'b0, "R10", "host_mode after power-on", host_mode, 0);
    @(negedge clk); #1; por_n = 1'b1;
    repeat (3) @(negedge clk);

    // standard mode, plain reset, latency
    hold_rst(30, -1);
    check(first_seen >= 0, "R2", "reset recognised", first_seen >= 0, 1);
    check(first_seen - t0 == 26, "R1", "reset latency", first_seen - t0, 26);
    check(run_normal == 1'b1 && host_mode == 1'b0, "R7", "normal after plain reset", run_normal, 1);

    // boundary: 23 samples twice, then 24
    hold_rst(23, -1);
    check(first_seen < 0, "R3", "short pulse ignored", first_seen >= 0, 0);
    hold_rst(23, -1);
    check(first_seen < 0, "R3", "count cleared between pulses", first_seen >= 0, 0);
    hold_rst(24, -1);
    check(first_seen >= 0, "R2", "threshold pulse resets", first_seen >= 0, 1);

    // qualified strobe edge -> host mode
    hold_rst(160, 150);
    check(host_mode == 1'b1 && run_normal == 1'b0, "R5", "host mode entered", host_mode, 1);

    // strobe activity and short pulse leave mode alone
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1; psen_pin = 1'b0;
      repeat (4) @(negedge clk); #1; psen_pin = 1'b1;
    end
    hold_rst(10, 2);
    check(host_mode == 1'b1 && run_normal == 1'b0, "R9", "mode held outside reset", host_mode, 1);

    // early strobe edge ignored
    hold_rst(160, 40);
    check(run_normal == 1'b1 && host_mode == 1'b0, "R6", "early edge ignored", run_normal, 1);

    // double-speed clock mode
    @(negedge clk); #1; half_cycle = 1'b1;
    hold_rst(80, 72);
    check(host_mode == 1'b1, "R4", "host mode with 6-clock cycle", host_mode, 1);
    hold_rst(11, -1);
    check(first_seen < 0, "R4", "11 samples below fast threshold", first_seen >= 0, 0);
    hold_rst(12, -1);
    check(first_seen >= 0, "R4", "12 samples reach fast threshold", first_seen >= 0, 1);
    check(run_normal == 1'b1 && host_mode == 1'b0, "R7", "normal after fast reset", run_normal, 1);
    check(core_rst == 1'b0, "R11", "reset negated after release", core_rst, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule